// File: doc/BRIEF.md
# Radio Antenna Switch and Event Status Registers

This peripheral sits beside a radio transceiver. It owns two pad outputs that normally carry general-purpose output data. Software can instead give them to an antenna transmit/receive switch. In that mode the first pad carries the switch level, which is high while a packet is being sent and low otherwise. The second pad carries the inverse of that level. Two 8-bit control registers choose the mode. The switch function is granted only when both registers hold the required key codes. A flag reports a half-written pairing.

The block also keeps a four-bit, active-low record of radio events: modem ready, transmit done, receive started and receive done. A one-cycle strobe on an event input drives its bit to 0. Several bits can sit at 0 at once. Software re-arms a bit by writing 1 to it. An interrupt request goes high while any bit is at 0 and enabled by a per-bit mask.

All registers share one synchronous write port. Read data is a combinational view of the register at the read address.

Top module: `rfsw_irq_regs`

## Requirements
- R1: After reset, the registers read as follows: address 0 (switch key A) is 0x00, address 1 (switch key B) is 0x00, address 2 (event status) is 0x0F and address 3 (interrupt enable mask) is 0x00. `irq_o` and `cfg_err_o` are 0.
- R2: When switch mode is not granted, `pad_o` equals `gpio_i`, bit for bit.
- R3: Switch mode is granted only when key A holds 0x50 and key B holds 0x00. In switch mode `pad_o[0]` is 1 whenever `radio_tx` is 1.
- R4: In switch mode, `pad_o[1]` is always the inverse of `pad_o[0]`.
- R5: In switch mode, when `radio_tx` is 0 (receiving or idle), `pad_o[0]` is 0 and `pad_o[1]` is 1.
- R6: A 1 on `ev_i[k]` at a clock edge makes status bit k read 0 from the next cycle on. The bit map is: bit 0 modem ready, bit 1 transmit end, bit 2 receive start, bit 3 receive end. Strobes on several bits in the same edge clear all of those bits together.
- R7: A write to address 2 sets every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R8: If an event strobe and a write of 1 hit the same status bit at the same edge, the bit ends at 0.
- R9: `irq_o` is 1 exactly when some status bit k is 0 and mask bit k is 1.
- R10: `cfg_err_o` is 1 exactly when key A holds 0x50 and key B holds a value other than 0x00.
- R11: Register writes take effect at the clock edge where `bus_we` is 1. `bus_rdata` shows the addressed register, and the unused upper bits of addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address: 0 key A, 1 key B, 2 status, 3 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ev_i | input | 4 | One-cycle radio event strobes, one per status bit |
| radio_tx | input | 1 | High while a packet is being transmitted |
| gpio_i | input | 2 | General-purpose output data for the two pads |
| pad_o | output | 2 | Pad drive: bit 0 switch level, bit 1 its inverse in switch mode |
| irq_o | output | 1 | Interrupt request |
| cfg_err_o | output | 1 | Key A granted but key B does not match |

## Verification
Key pairings are drawn from four groups: the granted pair, key A alone, key B alone, and unrelated values. Comparing the pads against `gpio_i` and against `radio_tx` shows whether the mux picked the right source, and shows a wrong key value or a swapped key check. Event strobes arrive singly, several at once, and in the same edge as status writes whose data bits are mixed 1s and 0s. This exposes a write-0 that wrongly clears, a write that beats an event, and a bit-map shift. Random masks against many status patterns test the interrupt gating apart from the status logic.

// File: rtl/rfsw_pkg.sv
// Package: register addresses shared by the switch/status block and its bench.
// Assumes a 2-bit register address space.
package rfsw_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_KEYA = 2'd0,
        A_KEYB = 2'd1,
        A_STAT = 2'd2,
        A_MASK = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/rfsw_ctl_regs.sv
// Control registers: two switch key registers and the interrupt enable mask.
// Decodes switch-mode grant and the configuration-error flag from the keys.
// Assumes EV_N <= DATA_W; reset is synchronous active-low.
module rfsw_ctl_regs
    import rfsw_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter int              EV_N   = 4,
    parameter logic [DATA_W-1:0] KEY_A = 8'h50,
    parameter logic [DATA_W-1:0] KEY_B = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] key_a_o,
    output logic [DATA_W-1:0] key_b_o,
    output logic [EV_N-1:0]   mask_o,
    output logic              sw_mode_o,
    output logic              cfg_err_o
);
    logic key_a_hit;
    logic key_b_hit;

    // Load the addressed control register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_a_o <= '0;
            key_b_o <= '0;
            mask_o  <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_KEYA:  key_a_o <= wr_data;
                A_KEYB:  key_b_o <= wr_data;
                A_MASK:  mask_o  <= wr_data[EV_N-1:0];
                default: ;
            endcase
        end
    end

    // Compare each key with its required code and decode the grant and error.
    always_comb begin
        key_a_hit = (key_a_o == KEY_A);
        key_b_hit = (key_b_o == KEY_B);
        sw_mode_o = key_a_hit && key_b_hit;
        cfg_err_o = key_a_hit && !key_b_hit;
    end
endmodule

// File: rtl/rfsw_evt_status.sv
// Active-low event status: an event strobe forces its bit to 0, and a write
// of 1 restores it. The event wins over a write in the same cycle. The
// interrupt request is any enabled bit at 0. Reset sets every bit to 1.
module rfsw_evt_status #(
    parameter int EV_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] ev_i,
    input  logic [EV_N-1:0] set_i,
    input  logic [EV_N-1:0] mask_i,
    output logic [EV_N-1:0] stat_o,
    output logic            irq_o
);
    genvar k;
    generate
        for (k = 0; k < EV_N; k++) begin : g_bit
            // One status bit: the event clears it, a write of 1 re-arms it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat_o[k] <= 1'b1;
                else if (ev_i[k])
                    stat_o[k] <= 1'b0;
                else if (set_i[k])
                    stat_o[k] <= 1'b1;
            end
        end
    endgenerate

    // Raise the request while any enabled bit is pending (0).
    always_comb begin
        irq_o = |(~stat_o & mask_i);
    end
endmodule

// File: rtl/rfsw_pin_mux.sv
// Pad steering: in switch mode pad 0 carries the transmit level and pad 1
// its inverse; otherwise both pads pass the GPIO data through.
// The resting level outside transmission is 0 on pad 0 (receive position).
module rfsw_pin_mux #(
    parameter int PAD_N = 2
) (
    input  logic             sw_mode_i,
    input  logic             tx_i,
    input  logic [PAD_N-1:0] gpio_i,
    output logic [PAD_N-1:0] pad_o
);
    // Choose between the switch pair and the GPIO data.
    always_comb begin
        pad_o = gpio_i;
        if (sw_mode_i) begin
            pad_o[0] = tx_i;
            pad_o[1] = ~tx_i;
        end
    end
endmodule

// File: rtl/rfsw_irq_regs.sv
// Top: radio antenna-switch pad control plus the active-low event status
// with a masked interrupt. One synchronous write port; the read data is a
// combinational view of the addressed register.
module rfsw_irq_regs
    import rfsw_pkg::*;
#(
    parameter int              DATA_W = 8,
    parameter int              EV_N   = 4,
    parameter logic [DATA_W-1:0] KEY_A = 8'h50,
    parameter logic [DATA_W-1:0] KEY_B = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [EV_N-1:0]   ev_i,
    input  logic              radio_tx,
    input  logic [1:0]        gpio_i,
    output logic [1:0]        pad_o,
    output logic              irq_o,
    output logic              cfg_err_o
);
    localparam int PAD_N = 2;

    logic [DATA_W-1:0] key_a_q;
    logic [DATA_W-1:0] key_b_q;
    logic [EV_N-1:0]   mask_q;
    logic [EV_N-1:0]   stat_q;
    logic [EV_N-1:0]   stat_set;
    logic              sw_mode;

    rfsw_ctl_regs #(
        .DATA_W (DATA_W),
        .EV_N   (EV_N),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .key_a_o   (key_a_q),
        .key_b_o   (key_b_q),
        .mask_o    (mask_q),
        .sw_mode_o (sw_mode),
        .cfg_err_o (cfg_err_o)
    );

    // Turn a status-address write into per-bit re-arm requests.
    always_comb begin
        stat_set = (bus_we && reg_addr_e'(bus_addr) == A_STAT) ? bus_wdata[EV_N-1:0] : '0;
    end

    rfsw_evt_status #(
        .EV_N (EV_N)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (ev_i),
        .set_i  (stat_set),
        .mask_i (mask_q),
        .stat_o (stat_q),
        .irq_o  (irq_o)
    );

    rfsw_pin_mux #(
        .PAD_N (PAD_N)
    ) u_mux (
        .sw_mode_i (sw_mode),
        .tx_i      (radio_tx),
        .gpio_i    (gpio_i),
        .pad_o     (pad_o)
    );

    // Read mux: present the addressed register, zero-extended.
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            A_KEYA: bus_rdata = key_a_q;
            A_KEYB: bus_rdata = key_b_q;
            A_STAT: bus_rdata[EV_N-1:0] = stat_q;
            A_MASK: bus_rdata[EV_N-1:0] = mask_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/rfsw_irq_chk.sv
// Checker for rfsw_irq_regs: temporal properties on pads, status and request.
// It is bound into the top and observes its ports and the status register.
module rfsw_irq_chk #(
    parameter int EV_N = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_we,
    input logic [1:0]      bus_addr,
    input logic [7:0]      bus_wdata,
    input logic [EV_N-1:0] ev_i,
    input logic            radio_tx,
    input logic [1:0]      gpio_i,
    input logic [1:0]      pad_o,
    input logic            irq_o,
    input logic [EV_N-1:0] stat,
    input logic [7:0]      key_a,
    input logic [7:0]      key_b
);
    logic granted;
    assign granted = (key_a == 8'h50) && (key_b == 8'h00);

    // R2: without the key pair the pads follow the GPIO data
    assert_gpio_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !granted |-> pad_o == gpio_i);

    // R3: transmit drives the switch level high
    assert_tx_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && radio_tx) |-> pad_o[0]);

    // R4: the second pad is the inverse of the first
    assert_pair_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> (pad_o[1] != pad_o[0]));

    // R6: a strobed bit reads 0 in the next cycle
    assert_evt_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((stat & $past(ev_i)) == '0));

    // R7: a status write only sets bits, never clears them
    assert_write_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2 && ev_i == '0) |=>
        stat == ($past(stat) | $past(bus_wdata[EV_N-1:0])));

    // R9: no pending bit means no request
    assert_idle_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '1) |-> !irq_o);
endmodule

bind rfsw_irq_regs rfsw_irq_chk #(.EV_N(EV_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ev_i      (ev_i),
    .radio_tx  (radio_tx),
    .gpio_i    (gpio_i),
    .pad_o     (pad_o),
    .irq_o     (irq_o),
    .stat      (stat_q),
    .key_a     (key_a_q),
    .key_b     (key_b_q)
);

// File: tb/sim_rfsw_irq_regs.sv
`timescale 1ns/1ps
// Bench: directed corners, then seeded random traffic against a bench model.
module sim_rfsw_irq_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] ev_i = '0;
    logic       radio_tx = 1'b0;
    logic [1:0] gpio_i = '0;
    logic [1:0] pad_o;
    logic       irq_o;
    logic       cfg_err_o;

    int total = 0;
    int bad = 0;

    logic [7:0] m_ka = 8'h00;
    logic [7:0] m_kb = 8'h00;
    logic [3:0] m_st = 4'hF;
    logic [3:0] m_mk = 4'h0;

    always #2 clk = ~clk;

    rfsw_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_i(ev_i),
        .radio_tx(radio_tx), .gpio_i(gpio_i), .pad_o(pad_o),
        .irq_o(irq_o), .cfg_err_o(cfg_err_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_ka;
            2'd1:    return m_kb;
            2'd2:    return {4'h0, m_st};
            default: return {4'h0, m_mk};
        endcase
    endfunction

    // Compare every output against the model and the held inputs.
    task automatic check_all(input string rd_tag);
        logic grant;
        grant = (m_ka == 8'h50) && (m_kb == 8'h00);
        if (grant) begin
            if (radio_tx) check("R3", {7'd0, pad_o[0]}, 8'd1);
            else          check("R5", {7'd0, pad_o[0]}, 8'd0);
            check("R4", {7'd0, pad_o[1]}, {7'd0, ~radio_tx});
        end else begin
            check("R2", {6'd0, pad_o}, {6'd0, gpio_i});
        end
        check("R9", {7'd0, irq_o}, {7'd0, |(~m_st & m_mk)});
        check("R10", {7'd0, cfg_err_o}, {7'd0, (m_ka == 8'h50) && (m_kb != 8'h00)});
        check(rd_tag, bus_rdata, exp_rd(bus_addr));
    endtask

    // Drive one cycle at the falling edge, update the model at the rising
    // edge, then check at the next falling edge.
    task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] wd,
                       input logic [3:0] ev, input logic tx, input logic [1:0] g,
                       input string rd_tag);
        bus_we = we; bus_addr = a; bus_wdata = wd; ev_i = ev; radio_tx = tx; gpio_i = g;
        @(posedge clk);
        if (we) begin
            case (a)
                2'd0: m_ka = wd;
                2'd1: m_kb = wd;
                2'd2: m_st = m_st | wd[3:0];
                default: m_mk = wd[3:0];
            endcase
        end
        m_st = m_st & ~ev;
        @(negedge clk);
        bus_we = 1'b0;
        ev_i = '0;
        check_all(rd_tag);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values of all four registers and the flags
        for (int a = 0; a < 4; a++) begin
            bus_addr = a[1:0];
            #0.5;
            check("R1", bus_rdata, (a == 2) ? 8'h0F : 8'h00);
        end
        check("R1", {6'd0, irq_o, cfg_err_o}, 8'h00);

        cyc(1, 2'd0, 8'h50, 4'h0, 1'b0, 2'b11, "R11");   // grant, idle -> R5
        cyc(0, 2'd0, 8'h00, 4'h0, 1'b1, 2'b00, "R3");    // transmit high
        cyc(0, 2'd1, 8'h00, 4'h0, 1'b0, 2'b01, "R5");
        cyc(1, 2'd1, 8'h33, 4'h0, 1'b1, 2'b10, "R10");   // broken pairing
        cyc(1, 2'd0, 8'h00, 4'h0, 1'b1, 2'b01, "R2");    // key A alone cleared
        cyc(1, 2'd1, 8'h00, 4'h0, 1'b0, 2'b10, "R2");
        cyc(0, 2'd2, 8'h00, 4'b1010, 1'b0, 2'b00, "R6"); // coinciding events
        cyc(1, 2'd2, 8'hF0, 4'h0, 1'b0, 2'b00, "R7");    // write 0s: no change
        cyc(1, 2'd2, 8'h0F, 4'b0010, 1'b0, 2'b00, "R8"); // event beats write
        check("R8", bus_rdata, 8'h0D);
        cyc(1, 2'd3, 8'hF2, 4'h0, 1'b0, 2'b00, "R9");    // enable bit 1
        check("R9", {7'd0, irq_o}, 8'd1);
        cyc(1, 2'd2, 8'h02, 4'h0, 1'b0, 2'b00, "R7");
        check("R7", bus_rdata, 8'h0F);
        check("R9", {7'd0, irq_o}, 8'd0);
        cyc(0, 2'd2, 8'h00, 4'b0001, 1'b0, 2'b00, "R6"); // modem ready is bit 0
        check("R6", bus_rdata, 8'h0E);

        for (int n = 0; n < 3000; n++) begin
            logic [1:0] a;
            logic [7:0] wd;
            logic [3:0] ev;
            a = 2'($urandom_range(0, 3));
            wd = 8'($urandom);
            case ($urandom_range(0, 3))
                0: wd = 8'h50;
                1: wd = 8'h00;
                default: ;
            endcase
            ev = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
            cyc($urandom_range(0, 1) == 1, a, wd, ev, 1'($urandom), 2'($urandom),
                (a == 2'd2) ? "R6" : "R11");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule